// File: doc/BRIEF.md
# Strap-Configured Indexed Register Port

This block sits on the host I/O bus of a card controller with two slots and gives the host access to a bank of byte-wide control registers through only two I/O locations. The even location holds an index byte. Its top bit names a device, the next bit names a slot, and the low six bits pick one register in that slot. The odd location is a data window onto the register the index currently points at. Each slot has its own 56-byte backing array.

Two strap pins configure the block when reset is released. Their levels are captured on the first clock edge after `rst_ni` rises and are ignored after that. The mode strap picks the decode mode. In internal decode the block compares the upper address bits against its own base pair. In external decode an outside decoder has already qualified the address, so only chip select and address bit 0 matter. The device strap sets the device number that the top bit of the index must carry before a data access is accepted. Several of these blocks can therefore share one index/data pair.

Top module: `idx_reg_port`

## Requirements
- R1: While `rst_ni` is low, the index register and every backing register clear to 00h. After release, the index reads 00h and any in-range register reads 00h.
- R2: In internal decode mode an access hits only when `cs_ni` is 0 and `addr_i[9:1]` equals the upper nine bits of 3E0h. Any other address is ignored: the read output-enable stays 0 and writes change nothing.
- R3: In external decode mode `addr_i[9:1]` is ignored. Any address with `cs_ni` at 0 hits, and `addr_i[0]` selects the location (0 = index, 1 = data).
- R4: With `cs_ni` at 1, no access takes place in either mode.
- R5: A hit write to the index location stores all 8 bits. A hit read of it returns the stored byte with output-enable 1, whatever the device bit holds.
- R6: The index layout is bit 7 = device, bit 6 = slot, bits 5..0 = register. A hit data write stores into the addressed register of that slot. A later data read of the same index returns the stored byte, and the two slots never alias.
- R7: If index bit 7 differs from the strapped device number, a data write is discarded and a data read leaves output-enable at 0.
- R8: A register number of 56 or higher reads as 00h with output-enable 1 when the device matches. Writes to such a number are discarded and alter no other register.
- R9: The mode strap (1 = internal decode) and the device strap are taken on the first clock after reset release. Later changes on those pins have no effect until the next reset.
- R10: `rdata_oe_o` is 1 only during a hit read (with `rd_i` at 1). Whenever it is 0, `rdata_o` is 00h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strap_mode_i | input | 1 | Decode-mode strap, 1 = internal decode |
| strap_dev_i | input | 1 | Device-number strap |
| cs_ni | input | 1 | Chip select, active low |
| addr_i | input | 10 | I/O address |
| wr_i | input | 1 | Write strobe, taken at the clock edge |
| rd_i | input | 1 | Read strobe, read data is combinational |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, 00h when not driven |
| rdata_oe_o | output | 1 | Read data valid / bus drive enable |

## Verification
The hardest cases are the strap-dependent ones. The device mismatch path needs a reset with a given device strap followed by an index whose top bit is the opposite. The decode-mode path needs whole reset phases in each mode. The bench runs separate reset phases for internal/device 0 and external/device 1, and flips the strap pins after capture so that a late change would show up as a wrongly accepted access. Inside each phase, random indexes cover both device bits, both slots and the range past the last register, and random addresses land on and off the base pair.

// File: rtl/idxp_pkg.sv
package idxp_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 10;
  localparam int REG_W  = 6;
  localparam int SLOTS  = 2;

  typedef struct packed {
    logic             dev;
    logic             slot;
    logic [REG_W-1:0] reg_idx;
  } idx_t;
endpackage

// File: rtl/idxp_strap.sv
module idxp_strap (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mode_pin_i,
  input  logic dev_pin_i,
  output logic int_dec_o,
  output logic dev_o,
  output logic armed_o
);
  // capture once on the first edge after reset release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      int_dec_o <= 1'b0;
      dev_o     <= 1'b0;
      armed_o   <= 1'b0;
    end else if (!armed_o) begin
      int_dec_o <= mode_pin_i;
      dev_o     <= dev_pin_i;
      armed_o   <= 1'b1;
    end
  end
endmodule

// File: rtl/idxp_decode.sv
module idxp_decode import idxp_pkg::*; #(
  parameter logic [ADDR_W-1:0] BASE_ADDR = 10'h3E0
) (
  input  logic              cs_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              int_dec_i,
  output logic              hit_o,
  output logic              data_sel_o
);
  logic base_match;

  assign base_match = (addr_i[ADDR_W-1:1] == BASE_ADDR[ADDR_W-1:1]);
  assign hit_o      = !cs_ni && (!int_dec_i || base_match);
  assign data_sel_o = addr_i[0];
endmodule

// File: rtl/idxp_regfile.sv
module idxp_regfile import idxp_pkg::*; #(
  parameter int NUM_REGS = 56
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              slot_i,
  input  logic [REG_W-1:0]  reg_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic              in_range;
  logic [DATA_W-1:0] slot_rd [SLOTS];

  assign in_range = (int'(reg_i) < NUM_REGS);

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic [DATA_W-1:0] mem_q [NUM_REGS];
    logic              slot_we;

    assign slot_we = we_i && in_range && (slot_i == 1'(s));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int r = 0; r < NUM_REGS; r++) mem_q[r] <= '0;
      end else if (slot_we) begin
        for (int r = 0; r < NUM_REGS; r++)
          if (reg_i == REG_W'(r)) mem_q[r] <= wdata_i;
      end
    end

    always_comb begin
      slot_rd[s] = '0;
      for (int r = 0; r < NUM_REGS; r++)
        if (reg_i == REG_W'(r)) slot_rd[s] = mem_q[r];
    end
  end

  assign rdata_o = in_range ? slot_rd[slot_i] : '0;
endmodule

// File: rtl/idx_reg_port.sv
module idx_reg_port import idxp_pkg::*; #(
  parameter int                NUM_REGS  = 56,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 10'h3E0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strap_mode_i,
  input  logic              strap_dev_i,
  input  logic              cs_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rdata_oe_o
);
  logic              int_dec_q, dev_q, armed_q;
  logic              hit, data_sel, acc, dev_ok, reg_we;
  idx_t              idx_q;
  logic [DATA_W-1:0] reg_rd;

  idxp_strap u_strap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_pin_i (strap_mode_i),
    .dev_pin_i  (strap_dev_i),
    .int_dec_o  (int_dec_q),
    .dev_o      (dev_q),
    .armed_o    (armed_q)
  );

  idxp_decode #(.BASE_ADDR(BASE_ADDR)) u_dec (
    .cs_ni      (cs_ni),
    .addr_i     (addr_i),
    .int_dec_i  (int_dec_q),
    .hit_o      (hit),
    .data_sel_o (data_sel)
  );

  // no access until straps are captured
  assign acc    = hit && armed_q;
  assign dev_ok = (idx_q.dev == dev_q);
  assign reg_we = acc && wr_i && data_sel && dev_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       idx_q <= '0;
    else if (acc && wr_i && !data_sel) idx_q <= idx_t'(wdata_i);
  end

  idxp_regfile #(.NUM_REGS(NUM_REGS)) u_rf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we),
    .slot_i  (idx_q.slot),
    .reg_i   (idx_q.reg_idx),
    .wdata_i (wdata_i),
    .rdata_o (reg_rd)
  );

  always_comb begin
    rdata_o    = '0;
    rdata_oe_o = 1'b0;
    if (acc && rd_i) begin
      if (!data_sel) begin
        rdata_o    = idx_q;
        rdata_oe_o = 1'b1;
      end else if (dev_ok) begin
        rdata_o    = reg_rd;
        rdata_oe_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/idxp_checker.sv
module idxp_checker #(
  parameter int         NUM_REGS  = 56,
  parameter logic [9:0] BASE_ADDR = 10'h3E0
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cs_ni,
  input logic [9:0] addr_i,
  input logic       rd_i,
  input logic       wr_i,
  input logic [7:0] rdata_o,
  input logic       rdata_oe_o,
  input logic [7:0] idx_q,
  input logic       dev_q,
  input logic       int_dec_q,
  input logic       armed_q
);
  a_r4_cs_high_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |-> !rdata_oe_o);

  a_r10_oe_needs_rd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |-> !rdata_oe_o);

  a_r10_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rdata_oe_o |-> (rdata_o == 8'h00));

  a_r9_straps_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |=> ($stable(int_dec_q) && $stable(dev_q) && armed_q));

  a_r5_idx_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni || !wr_i || addr_i[0]) |=> $stable(idx_q));

  a_r2_off_base_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_dec_q && addr_i[9:1] != BASE_ADDR[9:1]) |-> !rdata_oe_o);

  a_r7_mismatch_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i[0] && idx_q[7] != dev_q) |-> !rdata_oe_o);

  a_r8_oob_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_oe_o && addr_i[0] && int'(idx_q[5:0]) >= NUM_REGS) |-> (rdata_o == 8'h00));
endmodule

bind idx_reg_port idxp_checker #(.NUM_REGS(NUM_REGS), .BASE_ADDR(BASE_ADDR)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cs_ni      (cs_ni),
  .addr_i     (addr_i),
  .rd_i       (rd_i),
  .wr_i       (wr_i),
  .rdata_o    (rdata_o),
  .rdata_oe_o (rdata_oe_o),
  .idx_q      (idx_q),
  .dev_q      (dev_q),
  .int_dec_q  (int_dec_q),
  .armed_q    (armed_q)
);

// File: tb/test_idx_reg_port.sv
`timescale 1ns/1ps
module test_idx_reg_port;
  localparam int NREG = 56;

  logic       clk_i = 0, rst_ni = 0;
  logic       strap_mode_i = 1, strap_dev_i = 0;
  logic       cs_ni = 1, wr_i = 0, rd_i = 0;
  logic [9:0] addr_i = '0;
  logic [7:0] wdata_i = '0, rdata_o;
  logic       rdata_oe_o;

  int errors = 0, checks = 0;
  logic       m_int, m_dev;
  logic [7:0] m_idx;
  logic [7:0] m_mem [2][64];

  always #2 clk_i = ~clk_i;

  idx_reg_port i_idx_reg_port (.*);

  function automatic bit hit_f(logic [9:0] a, logic cs);
    return !cs && (!m_int || a[9:1] == 9'h1F0);
  endfunction

  task automatic chk(string tag, logic [7:0] d, logic oe, logic [7:0] ed, logic eoe);
    checks++;
    if (d !== ed || oe !== eoe) begin
      errors++;
      $display("FAIL %s: got data=%02h oe=%0b exp data=%02h oe=%0b", tag, d, oe, ed, eoe);
    end
  endtask

  task automatic do_wr(logic [9:0] a, logic cs, logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; cs_ni = cs; wdata_i = d; wr_i = 1;
    @(posedge clk_i); #1 wr_i = 0; cs_ni = 1;
    if (hit_f(a, cs)) begin
      if (!a[0]) m_idx = d;
      else if (m_idx[7] == m_dev && int'(m_idx[5:0]) < NREG) m_mem[m_idx[6]][m_idx[5:0]] = d;
    end
  endtask

  task automatic do_rd(logic [9:0] a, logic cs, string tag);
    logic [7:0] ed; logic eoe;
    @(negedge clk_i);
    addr_i = a; cs_ni = cs; rd_i = 1;
    #1;
    ed = 0; eoe = 0;
    if (hit_f(a, cs)) begin
      if (!a[0]) begin ed = m_idx; eoe = 1; end
      else if (m_idx[7] == m_dev) begin
        eoe = 1;
        ed = (int'(m_idx[5:0]) < NREG) ? m_mem[m_idx[6]][m_idx[5:0]] : 8'h00;
      end
    end
    chk(tag, rdata_o, rdata_oe_o, ed, eoe);
    rd_i = 0; cs_ni = 1;
  endtask

  task automatic do_reset(logic mode, logic dev);
    @(negedge clk_i);
    rst_ni = 0; strap_mode_i = mode; strap_dev_i = dev;
    m_int = mode; m_dev = dev; m_idx = 0;
    for (int s = 0; s < 2; s++) for (int r = 0; r < 64; r++) m_mem[s][r] = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    repeat (2) @(negedge clk_i);
    strap_mode_i = !mode; strap_dev_i = !dev;  // R9: late pin changes ignored
  endtask

  task automatic rand_phase(int n, logic [9:0] base);
    for (int i = 0; i < n; i++) begin
      logic [9:0] a; logic cs; int k;
      k = $urandom_range(0, 9);
      a = (k < 7) ? (base | 10'($urandom_range(0, 1))) : 10'($urandom);
      cs = ($urandom_range(0, 7) == 0);
      if (!a[0] && $urandom_range(0, 1) == 1) do_wr(a, cs, 8'($urandom));
      else if ($urandom_range(0, 2) == 0) do_wr(a, cs, 8'($urandom));
      else do_rd(a, cs, "R6 random");
    end
  endtask

  initial begin
    void'($urandom(32'h5eed1234));
    // phase 1: internal decode, device 0
    do_reset(1'b1, 1'b0);
    do_rd(10'h3E0, 0, "R1 index reset");
    do_wr(10'h3E0, 0, 8'h07);
    do_rd(10'h3E1, 0, "R1 reg reset");
    do_wr(10'h3E1, 0, 8'hA5);
    do_wr(10'h3E0, 0, 8'h47);
    do_rd(10'h3E1, 0, "R6 slot1 unaliased");
    do_wr(10'h3E1, 0, 8'h3C);
    do_rd(10'h3E1, 0, "R6 slot1 write");
    do_rd(10'h3E0, 0, "R5 index readback");
    do_wr(10'h3E0, 0, 8'h07);
    do_rd(10'h3E1, 0, "R6 slot0 kept");
    do_wr(10'h3E0, 0, 8'h38);
    do_wr(10'h3E1, 0, 8'hFF);
    do_rd(10'h3E1, 0, "R8 index 56 reads zero");
    do_wr(10'h3E0, 0, 8'h3F);
    do_wr(10'h3E1, 0, 8'hEE);
    do_rd(10'h3E1, 0, "R8 index 63 reads zero");
    do_wr(10'h3E0, 0, 8'h00);
    do_rd(10'h3E1, 0, "R8 no alias to reg 0");
    do_wr(10'h3E0, 0, 8'h87);
    do_wr(10'h3E1, 0, 8'h11);
    do_rd(10'h3E1, 0, "R7 mismatch read silent");
    do_rd(10'h3E0, 0, "R5 index with other device");
    do_wr(10'h3E0, 0, 8'h07);
    do_rd(10'h3E1, 0, "R7 mismatch write dropped");
    do_wr(10'h2E1, 0, 8'h99);
    do_rd(10'h3E1, 0, "R2 off-base write ignored");
    do_rd(10'h2E1, 0, "R2 off-base read silent");
    do_wr(10'h001, 0, 8'h55);
    do_rd(10'h001, 0, "R9 mode pin change ignored");
    do_wr(10'h3E1, 1, 8'h66);
    do_rd(10'h3E1, 1, "R4 cs high read");
    do_rd(10'h3E1, 0, "R4 cs high write dropped");
    @(negedge clk_i); addr_i = 10'h3E1; cs_ni = 0; rd_i = 0; #1;
    chk("R10 no rd no oe", rdata_o, rdata_oe_o, 8'h00, 1'b0);
    cs_ni = 1;
    rand_phase(600, 10'h3E0);
    // phase 2: external decode, device 1
    do_reset(1'b0, 1'b1);
    do_wr(10'h000, 0, 8'h87);
    do_rd(10'h3FF, 0, "R1 reg cleared by reset");
    do_wr(10'h123, 0, 8'h77);
    do_rd(10'h2A5, 0, "R3 external any address");
    do_rd(10'h156, 0, "R3 a0 selects index");
    do_wr(10'h3E1, 1, 8'h12);
    do_rd(10'h0F1, 0, "R4 cs high external");
    do_wr(10'h002, 0, 8'h07);
    do_rd(10'h003, 0, "R7 device 1 rejects bit7=0");
    do_wr(10'h002, 0, 8'hC2);
    do_wr(10'h003, 0, 8'h5A);
    do_rd(10'h3E1, 0, "R6 slot1 device1");
    rand_phase(600, 10'h100);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    errors++; checks++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule